// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits between a clock source and a group of clock outputs. It turns the whole group off and on in response to an active-low stop request that may arrive at any time, unrelated to the clock. It can also hold any single output of the group low through a per-output enable bit, which comes from a configuration register elsewhere in the chip. The stop request first passes through a synchronizer in the gated clock's domain. The gate enables then change only on the falling clock edge. As a result, an output only ever stops while low, and its first high phase after a restart has full width.

A group-kind parameter selects one of two variants. The processor-side variant has a two-stage synchronizer, so both its stop and restart latencies stay under four clock cycles. The peripheral-side variant has a single stage, so it stops one clock after the request is seen and restarts on the next rising edge. A mode input decides whether the stop request is obeyed at all. Only in mobile mode does a stop request gate the clocks. In desktop mode the request is ignored and only the enable bits gate the outputs. The request affects only the group attached to this instance.

Top module: `clk_stop_gate`

## Requirements
- R1: With `mobile_mode`=1, when `stop_req_n` is first sampled low at rising edge k, the high phase that begins at rising edge k+S is the first one suppressed on every output. S is 2 for the processor variant and 1 for the peripheral variant. The high phases that begin at edges before k+S pass unchanged.
- R2: With `mobile_mode`=1, when `stop_req_n` is first sampled high at rising edge k after a stop, the high phase that begins at rising edge k+S is the first one passed again, at full width.
- R3: A stopped or disabled output is held at 0. No output ever shows a high or low pulse shorter than half a clock period, even when `stop_req_n` toggles at arbitrary times.
- R4: The internal gate enables change only while `clk_src` is low.
- R5: Bit i of `out_en` controls `clk_gated[i]`. A value of 0 holds that output low, and a value of 1 lets it toggle. A change of `out_en` made while the clock is high takes effect from the next high phase.
- R6: With `mobile_mode`=0, `stop_req_n` has no effect on any output. Only `out_en` gates them.
- R7: While `rst_n` is low, all outputs are 0. Once reset is released, with `stop_req_n` high and `out_en` all ones, every output toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Ungated source clock of the group |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request for the group |
| mobile_mode | input | 1 | 1: obey the stop request; 0: ignore it |
| out_en | input | N_OUT | Per-output enable, 1 = toggle, 0 = hold low |
| clk_gated | output | N_OUT | Gated clock outputs |

## Verification
The stop request is driven 3 ns after a rising edge, so the design samples it at the next edge, k. The bench then expects the change on the high phase that begins at edge k+2 for the processor instance and at edge k+1 for the peripheral instance. Enable and mode changes are driven during a high phase, so each takes effect from the next high phase. The bench checks every output 2 to 3 ns into each high phase against a model built from these latencies. The model keeps its own sample pipeline per instance and updates its expected enables on the falling edge. For the phase in which the request toggles at random sub-cycle times, the model checks are switched off and only a monitor on pulse widths judges the outputs. The model checks resume once the request has been steady for several cycles.

// File: rtl/clk_gate_pkg.sv
`timescale 1ns/1ps
package clk_gate_pkg;
  typedef enum logic [0:0] {
    GRP_CPU = 1'b0,
    GRP_PCI = 1'b1
  } grp_kind_e;

  // Synchronizer depth per group variant: sets stop/start latency.
  function automatic int unsigned sync_depth(grp_kind_e kind);
    return (kind == GRP_PCI) ? 1 : 2;
  endfunction
endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/1ps
module stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_run,
  output logic run_sync
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b1;
        else        stage_q <= req_run;
      end
      assign run_sync = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], req_run};
      end
      assign run_sync = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gate_policy.sv
`timescale 1ns/1ps
module gate_policy #(
  parameter int unsigned N_OUT = 4
) (
  input  logic             run_sync,
  input  logic             mobile_mode,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] want_en
);
  logic group_run;
  // Desktop mode ignores the synchronized stop request.
  assign group_run = run_sync | ~mobile_mode;
  assign want_en   = out_en & {N_OUT{group_run}};
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en_d,
  output logic en_q,
  output logic clk_o
);
  // Enable captured on the falling edge, so it is steady through a high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end
  assign clk_o = clk & en_q;
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
  import clk_gate_pkg::*;
#(
  parameter int unsigned N_OUT = 4,
  parameter grp_kind_e   GROUP = GRP_CPU
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic             mobile_mode,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] clk_gated
);
  localparam int unsigned SYNC_STAGES = sync_depth(GROUP);

  logic             run_sync;
  logic [N_OUT-1:0] want_en;
  logic [N_OUT-1:0] gate_en;

  stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_src),
    .rst_n    (rst_n),
    .req_run  (stop_req_n),
    .run_sync (run_sync)
  );

  gate_policy #(.N_OUT(N_OUT)) u_policy (
    .run_sync    (run_sync),
    .mobile_mode (mobile_mode),
    .out_en      (out_en),
    .want_en     (want_en)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_cell
    clk_gate_cell u_cell (
      .clk   (clk_src),
      .rst_n (rst_n),
      .en_d  (want_en[i]),
      .en_q  (gate_en[i]),
      .clk_o (clk_gated[i])
    );
  end
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
  parameter int unsigned N_OUT = 4
) (
  input logic             clk_src,
  input logic             rst_n,
  input logic             mobile_mode,
  input logic [N_OUT-1:0] out_en,
  input logic             run_sync,
  input logic [N_OUT-1:0] gate_en,
  input logic [N_OUT-1:0] clk_gated
);
  // R1: a synchronized stop in mobile mode clears every gate enable.
  a_r1_stop_clears: assert property (@(negedge clk_src) disable iff (!rst_n)
    (mobile_mode && !run_sync) |=> (gate_en == '0));

  // R2: once running again, enables follow the configuration bits.
  a_r2_run_follows_cfg: assert property (@(negedge clk_src) disable iff (!rst_n)
    (mobile_mode && run_sync) |=> (gate_en == $past(out_en)));

  // R6: in desktop mode the stop request has no effect.
  a_r6_desktop_ignores: assert property (@(negedge clk_src) disable iff (!rst_n)
    (!mobile_mode) |=> (gate_en == $past(out_en)));

  // R3: an output whose enable is off showed no high level in the phase just ended.
  a_r3_low_when_gated: assert property (@(negedge clk_src) disable iff (!rst_n)
    ((clk_gated & ~gate_en) == '0));

  // R4: enables only move while the source clock is low.
  always @(gate_en) begin
    if (rst_n) begin
      a_r4_change_low: assert (clk_src == 1'b0)
        else $error("gate enable changed while clock high");
    end
  end
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_src     (clk_src),
  .rst_n       (rst_n),
  .mobile_mode (mobile_mode),
  .out_en      (out_en),
  .run_sync    (run_sync),
  .gate_en     (gate_en),
  .clk_gated   (clk_gated)
);

// File: tb/clk_stop_gate_tb_top.sv
`timescale 1ns/1ps
module clk_stop_gate_tb_top;
  import clk_gate_pkg::*;
  localparam int N = 4;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_n = 1'b1;
  logic mobile = 1'b1;
  logic [N-1:0] en = '1;
  logic [N-1:0] cpu_o, pci_o;

  always #5 clk = ~clk;  // 100 MHz

  clk_stop_gate #(.N_OUT(N), .GROUP(GRP_CPU)) dut_i (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_n),
    .mobile_mode(mobile), .out_en(en), .clk_gated(cpu_o));

  clk_stop_gate #(.N_OUT(N), .GROUP(GRP_PCI)) dut_pci_i (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_n),
    .mobile_mode(mobile), .out_en(en), .clk_gated(pci_o));

  int n_chk = 0;
  int n_err = 0;
  bit model_on = 1'b1;
  bit mon_on = 1'b0;

  // Latency model: request sampled on rising edges, enables taken on falling edges.
  logic [1:0] sh_c;
  logic       sh_p;
  logic [N-1:0] exp_c, exp_p;

  function automatic logic [N-1:0] want(logic [N-1:0] e, logic m, logic run);
    return e & {N{~m | run}};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin sh_c <= 2'b11; sh_p <= 1'b1; end
    else begin sh_c <= {sh_c[0], stop_n}; sh_p <= stop_n; end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin exp_c <= '0; exp_p <= '0; end
    else begin
      exp_c <= want(en, mobile, sh_c[1]);
      exp_p <= want(en, mobile, sh_p);
    end
  end

  // Pulse-width monitor (R3)
  logic [N-1:0] prev_c = '0, prev_p = '0;
  realtime t_c [N];
  realtime t_p [N];
  int viol = 0;
  int edges = 0;
  always @(cpu_o or pci_o) begin
    for (int i = 0; i < N; i++) begin
      if (cpu_o[i] !== prev_c[i]) begin
        if (mon_on && ($realtime - t_c[i]) < 4.9) begin
          viol++;
          $display("pulse short cpu out %0d width %0t", i, $realtime - t_c[i]);
        end
        t_c[i] = $realtime;
        edges++;
      end
      if (pci_o[i] !== prev_p[i]) begin
        if (mon_on && ($realtime - t_p[i]) < 4.9) begin
          viol++;
          $display("pulse short pci out %0d width %0t", i, $realtime - t_p[i]);
        end
        t_p[i] = $realtime;
        edges++;
      end
    end
    prev_c = cpu_o;
    prev_p = pci_o;
  end

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $realtime, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp_v, bit at_least);
    n_chk++;
    if (at_least ? (act < exp_v) : (act != exp_v)) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%s%0d", req, act, at_least ? ">=" : "", exp_v);
    end
  endtask

  // Advance to 3 ns after the next rising edge, checking the model at +2 ns.
  task automatic step();
    @(posedge clk);
    #2;
    if (model_on) begin
      chk("R1 R2 R5 R6 model cpu", cpu_o, exp_c);
      chk("R1 R2 R5 R6 model pci", pci_o, exp_p);
    end
    #1;
  endtask

  task automatic run_main();
    repeat (3) step();
    chk("R7 reset cpu low", cpu_o, '0);
    chk("R7 reset pci low", pci_o, '0);
    rst_n = 1'b1;
    step();
    mon_on = 1'b1;
    step();
    chk("R7 cpu running after reset", cpu_o, ALL);
    chk("R7 pci running after reset", pci_o, ALL);

    // Directed stop: sampled at edge k
    stop_n = 1'b0;
    step();                                   // edge k
    chk("R1 cpu on at k", cpu_o, ALL);
    chk("R1 pci on at k", pci_o, ALL);
    step();                                   // edge k+1
    chk("R1 cpu still on at k+1", cpu_o, ALL);
    chk("R1 pci off at k+1", pci_o, '0);
    step();                                   // edge k+2
    chk("R1 cpu off at k+2", cpu_o, '0);
    repeat (3) step();
    chk("R3 cpu held low", cpu_o, '0);
    chk("R3 pci held low", pci_o, '0);

    // Directed restart
    stop_n = 1'b1;
    step();
    chk("R2 cpu still off at k", cpu_o, '0);
    chk("R2 pci still off at k", pci_o, '0);
    step();
    chk("R2 pci on at k+1", pci_o, ALL);
    chk("R2 cpu off at k+1", cpu_o, '0);
    step();
    chk("R2 cpu on at k+2", cpu_o, ALL);

    // Per-output enables
    en = 4'b1010;
    step();
    chk("R5 cpu enables", cpu_o, 4'b1010);
    chk("R5 pci enables", pci_o, 4'b1010);
    en = 4'b0101;
    step();
    chk("R5 cpu enables swapped", cpu_o, 4'b0101);
    en = ALL;
    step();

    // Desktop mode ignores the stop request
    mobile = 1'b0;
    stop_n = 1'b0;
    repeat (5) step();
    chk("R6 cpu ignores stop", cpu_o, ALL);
    chk("R6 pci ignores stop", pci_o, ALL);
    stop_n = 1'b1;
    mobile = 1'b1;
    repeat (3) step();

    // Constrained random, edge-aligned stimulus, checked against the model
    for (int c = 0; c < 400; c++) begin
      step();
      if ($urandom_range(7) == 0)  stop_n = ~stop_n;
      if ($urandom_range(15) == 0) en = N'($urandom);
      if ($urandom_range(31) == 0) mobile = ~mobile;
    end

    // Request toggling at arbitrary instants: only pulse widths judged
    mobile = 1'b1;
    en = ALL;
    step();
    model_on = 1'b0;
    for (int c = 0; c < 80; c++) begin
      #($urandom_range(3, 400) * 0.1);
      stop_n = ~stop_n;
    end
    step();
    stop_n = 1'b1;
    repeat (5) step();
    model_on = 1'b1;
    repeat (5) step();
    chk("R2 cpu running after async phase", cpu_o, ALL);

    chk_int("R3 no short pulse", viol, 0, 1'b0);
    chk_int("R3 outputs toggled", edges, 1000, 1'b1);
  endtask

  initial begin
    bit wd;
    void'($urandom(32'h5eed1234));
    wd = 1'b0;
    fork
      run_main();
      begin #1_000_000; wd = 1'b1; end
    join_any
    disable fork;
    if (wd) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule